// File: doc/BRIEF.md
# Transmit Symbol Serializer with RF Power Sequencing

This block turns bytes handed over by software into a timed serial bit stream for a radio transmitter front end, and it switches the RF chain on and off around each burst. Bytes enter through a ready/valid port that has one byte of buffering. Software can therefore hand over the next byte while the current byte is still being sent, and consecutive bytes go out with no gap.

When a byte is waiting and the block is idle, it enables the oscillator, then the divider, then the amplifier. Each stage has its own programmable warmup count. Bits are then sent least significant first, and each bit lasts a programmable number of clocks. In on-off keying mode, a 1 ramps the amplifier level slice count up to a programmed maximum and a 0 ramps it down to zero. In frequency-shift mode, the amplifier ramps up once and stays on, and a 7-bit deviation word is driven for each 1 bit. After the last bit, if no byte is waiting, the chain powers down in reverse order.

Test inputs can force the three enables on, repeat the current byte indefinitely, or hold the deviation output at its programmed word.

Top module: `tx_symbol_serializer`

## Requirements
- R1: `in_ready` is high exactly when the holding register is empty. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge. A byte handed over while another is being sent follows it with no idle symbol in between.
- R2: A programmed symbol time N makes every bit last exactly N+1 clocks on `tx_bit`. Bit 0 of each byte is sent first. `tx_bit` is 0 outside a burst.
- R3: At burst start, `osc_en` rises first. `div_en` rises (oscillator warmup)+1 clocks later. `amp_en` rises (divider warmup)+1 clocks after that. The first bit starts (amplifier warmup)+1 clocks after `amp_en` rises.
- R4: `amp_level` moves by exactly one slice per step. A step time N gives one step every N+1 clocks. The first step comes N+1 clocks after the target level changes from a settled value.
- R5: In on-off keying mode (`cfg_fsk_mode`=0), a 1 bit sets the level target to `cfg_level_max` and a 0 bit sets it to 0. `dev_out` stays 0.
- R6: In frequency-shift mode (`cfg_fsk_mode`=1), `dev_out` equals `cfg_dev_word` during a 1 bit and is 0 during a 0 bit. The level target is `cfg_level_max` for the whole burst.
- R7: If a byte's last bit ends with the holding register empty, `amp_en` falls on the next clock and `amp_level` reads 0. `div_en` falls one clock later. `osc_en` falls, and `idle` rises, one clock after that.
- R8: `tst_force_osc`, `tst_force_div` and `tst_force_amp` each drive their own enable high even while idle. Each leaves the other enables and `idle` unchanged.
- R9: While `tst_repeat` is high, the byte in flight is sent again at each byte end. After `tst_repeat` is cleared, the current repetition finishes and the normal rules apply.
- R10: `tst_force_dev` drives `dev_out` to `cfg_dev_word` whatever the mode, the state or the data.
- R11: After reset, `idle`=1, `in_ready`=1, and all enables, `amp_level`, `dev_out` and `tx_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fsk_mode | input | 1 | 1 selects frequency shift, 0 selects on-off keying |
| cfg_symbol_time | input | TIME_W (16) | Bit period minus one, in clocks |
| cfg_step_time | input | TIME_W (16) | Level ramp step period minus one, in clocks |
| cfg_level_max | input | LEVEL_W (5) | Full-on amplifier slice count |
| cfg_dev_word | input | DEV_W (7) | Deviation word for a 1 bit |
| cfg_osc_warm | input | TIME_W (16) | Oscillator warmup minus one |
| cfg_div_warm | input | TIME_W (16) | Divider warmup minus one |
| cfg_amp_warm | input | TIME_W (16) | Amplifier warmup minus one |
| tst_force_osc | input | 1 | Force oscillator enable |
| tst_force_div | input | 1 | Force divider enable |
| tst_force_amp | input | 1 | Force amplifier enable |
| tst_repeat | input | 1 | Resend the current byte at each byte end |
| tst_force_dev | input | 1 | Force the deviation output to the programmed word |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W (8) | Offered byte |
| in_ready | output | 1 | Holding register empty |
| osc_en | output | 1 | Oscillator enable |
| div_en | output | 1 | Divider enable |
| amp_en | output | 1 | Amplifier enable |
| amp_level | output | LEVEL_W (5) | Amplifier slice count |
| dev_out | output | DEV_W (7) | Frequency deviation word |
| tx_bit | output | 1 | Current data bit |
| idle | output | 1 | RF chain fully off |

## Verification
The hardest case to reach from the ports is a level ramp that starts from a settled level at a bit boundary that is also a byte boundary, while the next byte is already in the holding register. Reaching it needs the handshake, the symbol timer and the step timer all lined up in the same cycle. The stimulus chooses symbol times that are long enough for every ramp to settle, and it hands over each following byte as soon as `in_ready` rises, so that byte joins are gapless. A scoreboard then predicts the exact clock of every enable edge, of every bit and of the first ramp step. The repeat mode is cleared at a computed clock in the middle of the third repetition. This shows that the burst ends only at a byte boundary.

// File: rtl/txs_pkg.sv
package txs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WARM_OSC,
      ST_WARM_DIV,
      ST_WARM_AMP,
      ST_SEND,
      ST_OFF_AMP,
      ST_OFF_DIV
   } txs_state_e;

   // oscillator is on in every state except idle
   function automatic logic osc_on(txs_state_e s);
      return s != ST_IDLE;
   endfunction

   function automatic logic div_on(txs_state_e s);
      return (s == ST_WARM_DIV) || (s == ST_WARM_AMP) ||
             (s == ST_SEND)     || (s == ST_OFF_AMP);
   endfunction

   function automatic logic amp_on(txs_state_e s);
      return (s == ST_WARM_AMP) || (s == ST_SEND);
   endfunction

endpackage

// File: rtl/txs_countdown.sv
// Loadable down-counter; holds at zero. A load of N gives N+1 cycles to zero.
module txs_countdown #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

   // R2/R4: an expired timer stays expired until reloaded
   a_r2_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/txs_hold_reg.sv
// One-byte holding register in front of the shifter.
module txs_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end
   end

   assign in_ready = !full_q;
   assign full     = full_q;
   assign data     = data_q;

   // R1: a waiting byte is never overwritten by an offer
   a_r1_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !take) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/txs_sequencer.sv
// Power sequencing FSM, symbol timer and data shifter.
module txs_sequencer
   import txs_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int TIME_W    = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   input  logic [TIME_W-1:0] symbol_time,
   input  logic [TIME_W-1:0] osc_warm,
   input  logic [TIME_W-1:0] div_warm,
   input  logic [TIME_W-1:0] amp_warm,
   input  logic              repeat_byte,
   output txs_state_e        state,
   output logic              tx_bit
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   txs_state_e        state_q, state_d;
   logic [DATA_W-1:0] shift_q, cur_q, shifted;
   logic [IDX_W-1:0]  idx_q;
   logic              head;
   logic              tmr_load, tmr_zero;
   logic [TIME_W-1:0] tmr_val;
   logic              do_step, do_reload;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign head    = shift_q[0];
         assign shifted = shift_q >> 1;
      end else begin : g_msb_first
         assign head    = shift_q[DATA_W-1];
         assign shifted = shift_q << 1;
      end
   endgenerate

   txs_countdown #(.W(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      take      = 1'b0;
      do_step   = 1'b0;
      do_reload = 1'b0;
      case (state_q)
         ST_IDLE: if (hold_full) begin
            state_d  = ST_WARM_OSC;
            tmr_load = 1'b1;
            tmr_val  = osc_warm;
         end
         ST_WARM_OSC: if (tmr_zero) begin
            state_d  = ST_WARM_DIV;
            tmr_load = 1'b1;
            tmr_val  = div_warm;
         end
         ST_WARM_DIV: if (tmr_zero) begin
            state_d  = ST_WARM_AMP;
            tmr_load = 1'b1;
            tmr_val  = amp_warm;
         end
         ST_WARM_AMP: if (tmr_zero) begin
            state_d  = ST_SEND;
            tmr_load = 1'b1;
            tmr_val  = symbol_time;
            take     = 1'b1;
         end
         ST_SEND: if (tmr_zero) begin
            tmr_val = symbol_time;
            if (idx_q != LAST_IDX) begin
               do_step  = 1'b1;
               tmr_load = 1'b1;
            end else if (repeat_byte) begin
               do_reload = 1'b1;
               tmr_load  = 1'b1;
            end else if (hold_full) begin
               take     = 1'b1;
               tmr_load = 1'b1;
            end else begin
               state_d = ST_OFF_AMP;
            end
         end
         ST_OFF_AMP: state_d = ST_OFF_DIV;
         ST_OFF_DIV: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shift_q <= '0;
         cur_q   <= '0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            shift_q <= hold_data;
            cur_q   <= hold_data;
            idx_q   <= '0;
         end else if (do_reload) begin
            shift_q <= cur_q;
            idx_q   <= '0;
         end else if (do_step) begin
            shift_q <= shifted;
            idx_q   <= idx_q + IDX_W'(1);
         end
      end
   end

   assign state  = state_q;
   assign tx_bit = (state_q == ST_SEND) && head;

   // R2: the bit on the line only changes when the symbol timer expires
   a_r2_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && !tmr_zero) |=> $stable(tx_bit));
   // R3: the divider stage always follows the oscillator stage
   a_r3_up_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WARM_OSC) |=> (state_q == ST_WARM_OSC || state_q == ST_WARM_DIV));
   // R7: shutdown steps one stage per clock
   a_r7_down_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF_AMP) |=> (state_q == ST_OFF_DIV));
   // R1: the shifter only loads from a full holding register
   a_r1_take_full: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> hold_full);

endmodule

// File: rtl/txs_level_ramp.sv
// Amplifier slice ramp: one slice toward the target per step tick.
module txs_level_ramp #(
   parameter int LEVEL_W = 5,
   parameter int TIME_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [LEVEL_W-1:0] target,
   input  logic [TIME_W-1:0]  step_time,
   output logic [LEVEL_W-1:0] level
);

   logic [LEVEL_W-1:0] lvl_q;
   logic               at_target, step_zero, tick;

   assign at_target = (lvl_q == target);
   assign tick      = step_zero && !at_target;

   // settled: keep the step timer reloaded so a new target waits a full period
   txs_countdown #(.W(TIME_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (at_target || tick),
      .load_val (step_time),
      .zero     (step_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= '0;
      else if (!enable) lvl_q <= '0;
      else if (tick)    lvl_q <= (target > lvl_q) ? lvl_q + LEVEL_W'(1) : lvl_q - LEVEL_W'(1);
   end

   assign level = enable ? lvl_q : '0;

   // R4: the level never jumps more than one slice while enabled
   a_r4_one_slice: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (!enable || lvl_q == $past(lvl_q) ||
                  lvl_q == $past(lvl_q) + LEVEL_W'(1) ||
                  lvl_q + LEVEL_W'(1) == $past(lvl_q)));

endmodule

// File: rtl/tx_symbol_serializer.sv
module tx_symbol_serializer
   import txs_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int TIME_W    = 16,
   parameter int LEVEL_W   = 5,
   parameter int DEV_W     = 7,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_fsk_mode,
   input  logic [TIME_W-1:0]  cfg_symbol_time,
   input  logic [TIME_W-1:0]  cfg_step_time,
   input  logic [LEVEL_W-1:0] cfg_level_max,
   input  logic [DEV_W-1:0]   cfg_dev_word,
   input  logic [TIME_W-1:0]  cfg_osc_warm,
   input  logic [TIME_W-1:0]  cfg_div_warm,
   input  logic [TIME_W-1:0]  cfg_amp_warm,
   input  logic               tst_force_osc,
   input  logic               tst_force_div,
   input  logic               tst_force_amp,
   input  logic               tst_repeat,
   input  logic               tst_force_dev,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_data,
   output logic               in_ready,
   output logic               osc_en,
   output logic               div_en,
   output logic               amp_en,
   output logic [LEVEL_W-1:0] amp_level,
   output logic [DEV_W-1:0]   dev_out,
   output logic               tx_bit,
   output logic               idle
);

   generate
      if (DATA_W < 2 || TIME_W < 2 || LEVEL_W < 1 || DEV_W < 1) begin : g_bad_params
         $error("tx_symbol_serializer: parameter out of range");
      end
   endgenerate

   txs_state_e         state;
   logic               take, hold_full, sending;
   logic [DATA_W-1:0]  hold_data;
   logic [LEVEL_W-1:0] ramp_target;

   txs_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .take     (take),
      .full     (hold_full),
      .data     (hold_data)
   );

   txs_sequencer #(
      .DATA_W    (DATA_W),
      .TIME_W    (TIME_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_full   (hold_full),
      .hold_data   (hold_data),
      .take        (take),
      .symbol_time (cfg_symbol_time),
      .osc_warm    (cfg_osc_warm),
      .div_warm    (cfg_div_warm),
      .amp_warm    (cfg_amp_warm),
      .repeat_byte (tst_repeat),
      .state       (state),
      .tx_bit      (tx_bit)
   );

   assign sending = (state == ST_SEND);
   assign osc_en  = osc_on(state) || tst_force_osc;
   assign div_en  = div_on(state) || tst_force_div;
   assign amp_en  = amp_on(state) || tst_force_amp;
   assign idle    = (state == ST_IDLE);

   // FSK keeps the amplifier at full level; OOK follows the data
   assign ramp_target = (sending && (cfg_fsk_mode || tx_bit)) ? cfg_level_max : '0;

   txs_level_ramp #(
      .LEVEL_W (LEVEL_W),
      .TIME_W  (TIME_W)
   ) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (amp_en),
      .target    (ramp_target),
      .step_time (cfg_step_time),
      .level     (amp_level)
   );

   assign dev_out = (tst_force_dev || (sending && cfg_fsk_mode && tx_bit)) ? cfg_dev_word : '0;

   // R6: a 1 bit in FSK mode carries the deviation word
   a_r6_dev_on_one: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fsk_mode && tx_bit) |-> dev_out == cfg_dev_word);
   // R3: amplifier never on without the divider unless forced
   a_r3_amp_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_en && !tst_force_amp && !tst_force_div) |-> div_en);
   // R7: an idle chain drives no amplifier level
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !tst_force_amp) |-> amp_level == '0);

endmodule

// File: tb/tb_tx_symbol_serializer.sv
module tb_tx_symbol_serializer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_fsk_mode = 1'b0;
   logic [15:0] cfg_symbol_time = '0, cfg_step_time = '0;
   logic [4:0]  cfg_level_max = '0;
   logic [6:0]  cfg_dev_word = '0;
   logic [15:0] cfg_osc_warm = '0, cfg_div_warm = '0, cfg_amp_warm = '0;
   logic        tst_force_osc = 1'b0, tst_force_div = 1'b0, tst_force_amp = 1'b0;
   logic        tst_repeat = 1'b0, tst_force_dev = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, osc_en, div_en, amp_en, tx_bit, idle;
   logic [4:0]  amp_level;
   logic [6:0]  dev_out;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   mon_busy = 1'b0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   tx_symbol_serializer dut (
      .clk(clk), .rst_n(rst_n), .cfg_fsk_mode(cfg_fsk_mode),
      .cfg_symbol_time(cfg_symbol_time), .cfg_step_time(cfg_step_time),
      .cfg_level_max(cfg_level_max), .cfg_dev_word(cfg_dev_word),
      .cfg_osc_warm(cfg_osc_warm), .cfg_div_warm(cfg_div_warm), .cfg_amp_warm(cfg_amp_warm),
      .tst_force_osc(tst_force_osc), .tst_force_div(tst_force_div), .tst_force_amp(tst_force_amp),
      .tst_repeat(tst_repeat), .tst_force_dev(tst_force_dev),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .osc_en(osc_en), .div_en(div_en), .amp_en(amp_en), .amp_level(amp_level),
      .dev_out(dev_out), .tx_bit(tx_bit), .idle(idle)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // driver: offer a byte, push it to the scoreboard once taken
   task automatic put_byte(input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      exp_q.push_back(d);
   endtask

   task automatic wait_done();
      repeat (3) @(negedge clk);
      while (!(idle && !mon_busy && exp_q.size() == 0)) @(negedge clk);
   endtask

   // monitor: predicts enable edges, bits and ramp points from the requirements
   initial begin : monitor
      int sym_i, n_i, max_i, lvl_prev, tgt;
      logic [7:0] byte_v;
      logic       bit_v;
      forever begin
         @(negedge clk);
         if (!rst_n || idle) continue;
         mon_busy = 1'b1;
         sym_i = int'(cfg_symbol_time);
         n_i   = int'(cfg_step_time);
         max_i = int'(cfg_level_max);
         chk(osc_en && !div_en && !amp_en, "R3 osc first", int'({osc_en, div_en, amp_en}), 4);
         repeat (int'(cfg_osc_warm)) @(negedge clk);
         chk(!div_en, "R3 div early", int'(div_en), 0);
         @(negedge clk);
         chk(div_en && !amp_en, "R3 div rise", int'({div_en, amp_en}), 2);
         repeat (int'(cfg_div_warm)) @(negedge clk);
         chk(!amp_en, "R3 amp early", int'(amp_en), 0);
         @(negedge clk);
         chk(amp_en, "R3 amp rise", int'(amp_en), 1);
         repeat (int'(cfg_amp_warm) + 1) @(negedge clk);
         lvl_prev = 0;
         do begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1 scoreboard underrun", 0, 1);
               break;
            end
            byte_v = exp_q.pop_front();
            for (int b = 0; b < 8; b++) begin
               bit_v = byte_v[b];
               tgt   = (cfg_fsk_mode || bit_v) ? max_i : 0;
               for (int j = 0; j <= sym_i; j++) begin
                  if (j == 0) begin
                     chk(tx_bit == bit_v, "R2 bit start", int'(tx_bit), int'(bit_v));
                     if (cfg_fsk_mode)
                        chk(dev_out == (bit_v ? cfg_dev_word : 7'd0), "R6 deviation",
                            int'(dev_out), bit_v ? int'(cfg_dev_word) : 0);
                     else
                        chk(dev_out == 7'd0, "R5 no deviation", int'(dev_out), 0);
                  end
                  if (tgt != lvl_prev && j == n_i)
                     chk(int'(amp_level) == lvl_prev, "R4 before step", int'(amp_level), lvl_prev);
                  if (tgt != lvl_prev && j == n_i + 1)
                     chk(int'(amp_level) == lvl_prev + ((tgt > lvl_prev) ? 1 : -1), "R4 first step",
                         int'(amp_level), lvl_prev + ((tgt > lvl_prev) ? 1 : -1));
                  if (j == sym_i) begin
                     chk(tx_bit == bit_v, "R2 bit end", int'(tx_bit), int'(bit_v));
                     chk(int'(amp_level) == tgt, cfg_fsk_mode ? "R6 level" : "R5 level",
                         int'(amp_level), tgt);
                  end
                  @(negedge clk);
               end
               lvl_prev = tgt;
            end
         end while (exp_q.size() != 0);
         chk(!amp_en && div_en && osc_en && amp_level == 5'd0, "R7 amp off",
             int'({amp_en, div_en, osc_en}), 3);
         @(negedge clk);
         chk(!div_en && osc_en && !idle, "R7 div off", int'({div_en, osc_en, idle}), 2);
         @(negedge clk);
         chk(!osc_en && idle && !tx_bit, "R7 osc off", int'({osc_en, idle}), 1);
         mon_busy = 1'b0;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(idle && in_ready, "R11 idle/ready", int'({idle, in_ready}), 3);
      chk(!osc_en && !div_en && !amp_en, "R11 enables", int'({osc_en, div_en, amp_en}), 0);
      chk(amp_level == 0 && dev_out == 0 && !tx_bit, "R11 outputs",
          int'(amp_level) + int'(dev_out) + int'(tx_bit), 0);

      // R8 / R10 test overrides while idle
      cfg_dev_word = 7'h33;
      tst_force_osc = 1'b1;
      @(negedge clk);
      chk(osc_en && !div_en && !amp_en && idle, "R8 force osc", int'({osc_en, div_en, amp_en, idle}), 9);
      tst_force_osc = 1'b0; tst_force_div = 1'b1;
      @(negedge clk);
      chk(!osc_en && div_en && !amp_en && idle, "R8 force div", int'({osc_en, div_en, amp_en, idle}), 5);
      tst_force_div = 1'b0; tst_force_amp = 1'b1;
      @(negedge clk);
      chk(!osc_en && !div_en && amp_en && idle, "R8 force amp", int'({osc_en, div_en, amp_en, idle}), 3);
      tst_force_amp = 1'b0; tst_force_dev = 1'b1;
      @(negedge clk);
      chk(dev_out == 7'h33, "R10 force deviation", int'(dev_out), 'h33);
      tst_force_dev = 1'b0;
      @(negedge clk);
      chk(dev_out == 0 && !osc_en && !div_en && !amp_en, "R10 override released",
          int'(dev_out) + int'({osc_en, div_en, amp_en}), 0);

      // OOK burst of three gapless bytes (R1, R2, R3, R4, R5, R7)
      cfg_fsk_mode = 1'b0; cfg_symbol_time = 16'd23; cfg_step_time = 16'd2;
      cfg_level_max = 5'd6; cfg_osc_warm = 16'd5; cfg_div_warm = 16'd3; cfg_amp_warm = 16'd7;
      put_byte(8'hB4);
      put_byte(8'h01);
      chk(!in_ready, "R1 ready low while holding", int'(in_ready), 0);
      put_byte(8'hFF);
      wait_done();

      // FSK burst with zero oscillator warmup (R3, R6)
      cfg_fsk_mode = 1'b1; cfg_symbol_time = 16'd31; cfg_step_time = 16'd3;
      cfg_level_max = 5'd5; cfg_dev_word = 7'h5A;
      cfg_osc_warm = 16'd0; cfg_div_warm = 16'd1; cfg_amp_warm = 16'd2;
      put_byte(8'h3C);
      put_byte(8'hC5);
      wait_done();

      // R9 repeat mode: released during the third repetition
      cfg_fsk_mode = 1'b0; cfg_symbol_time = 16'd9; cfg_step_time = 16'd0;
      cfg_level_max = 5'd3; cfg_osc_warm = 16'd1; cfg_div_warm = 16'd1; cfg_amp_warm = 16'd1;
      tst_repeat = 1'b1;
      put_byte(8'h96);
      exp_q.push_back(8'h96);
      exp_q.push_back(8'h96);
      while (idle) @(negedge clk);
      repeat (2 + 2 + 2 + 2 * 8 * 10 + 4 * 10) @(negedge clk);
      tst_repeat = 1'b0;
      wait_done();
      chk(in_ready && idle, "R9 back to idle after repeat", int'({in_ready, idle}), 3);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule